// File: doc/BRIEF.md
# System Counter with One-Shot Compare

This block is a 56-bit free-running time base with one compare channel. It drives a level interrupt for one-shot timer events. The counter advances by one on every clock in which the tick enable is high, and it wraps to zero after its all-ones value. Software cannot load it. The counter can be read at any time through a read-only counter window.

A separate compare window holds three registers: the compare value as a low word and an upper word, and a control register. The control register has an arm bit, a mask bit and a read-only status bit. While the block is armed, the status bit sets once the counter is equal to or past the compare value, and it stays set. The only way to clear it is to write the arm bit to 0. Software re-arms the channel in three steps: write the arm bit to 0, write a new compare value, and write the arm bit to 1.

Counter reads are not latched. A reader gets a coherent 56-bit value by reading the upper word, then the lower word, then the upper word again, and retrying if the two upper reads differ.

Top module: `sysctr_cmp`

## Requirements
- R1: The counter increments by one on each rising clock edge at which `tick_en` is 1. It holds when `tick_en` is 0, and it wraps from 2^56-1 to 0.
- R2: The counter window returns live values with no latching: offset 0x08 gives counter bits 31:0, and offset 0x0C gives counter bits 55:32 in data bits 23:0, with bits 31:24 zero. The counter window has no write path.
- R3: In the compare window, a write to offset 0x20 sets compare bits 31:0. A write to offset 0x24 sets compare bits 55:32 from data bits 23:0, and data bits 31:24 are ignored. Reading either offset returns the stored value, and bits 31:24 at 0x24 read as zero.
- R4: Offset 0x2C of the compare window is the control register. Bit 0 is arm and bit 1 is mask, and both can be written and read. Bit 2 is the status bit, which reads the status but ignores writes. Bits 31:3 read as zero.
- R5: The status bit sets at the clock edge that follows any cycle in which arm is 1 and the counter is greater than or equal to the compare value. A compare value already in the past therefore fires one cycle after arming. Status stays set while arm stays 1.
- R6: Status clears only through a control write with data bit 0 equal to 0. A control write that keeps arm at 1 does not clear status, whatever value it gives bit 2.
- R7: `irq` is a level output equal to the status bit AND NOT the mask bit.
- R8: After reset, the counter, both compare words, arm, mask and status are all zero, and `irq` is 0.
- R9: Unmapped offsets in either window read as zero, and writes to them change nothing. Read data is zero when the window's read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| cnt_rd | input | 1 | Counter window read strobe |
| cnt_addr | input | 8 | Counter window byte offset |
| cnt_rdata | output | 32 | Counter window read data (combinational) |
| cmp_rd | input | 1 | Compare window read strobe |
| cmp_wr | input | 1 | Compare window write strobe |
| cmp_addr | input | 8 | Compare window byte offset |
| cmp_wdata | input | 32 | Compare window write data |
| cmp_rdata | output | 32 | Compare window read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The state of this block is the counter, the compare value and three control bits, and the read paths expose all of it combinationally in the cycle after any edge that changes it. A wrong counter value or a wrong compare value shows at the next read of the matching window offset. A wrong status bit shows on `irq` in the same cycle unless the mask is set, and always shows at the control offset. The bench compares every output against a behavioural model on every clock. Any divergence, such as a one-cycle-late status set, a strict instead of inclusive comparison, or a stray clear, is therefore caught in the first cycle it exists.

// File: rtl/sysctr_cmp.sv
module sysctr_cmp #(
  parameter int CW = 56,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cnt_rd,
  input  logic [AW-1:0] cnt_addr,
  output logic [31:0]   cnt_rdata,
  input  logic          cmp_rd,
  input  logic          cmp_wr,
  input  logic [AW-1:0] cmp_addr,
  input  logic [31:0]   cmp_wdata,
  output logic [31:0]   cmp_rdata,
  output logic          irq
);
  localparam int HW = CW - 32;
  localparam int PW = 32 - HW;
  localparam logic [AW-1:0] OFS_CNT_LO = AW'(8'h08);
  localparam logic [AW-1:0] OFS_CNT_HI = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_CMP_LO = AW'(8'h20);
  localparam logic [AW-1:0] OFS_CMP_HI = AW'(8'h24);
  localparam logic [AW-1:0] OFS_CTRL   = AW'(8'h2C);

  logic [CW-1:0] count_q;
  logic [CW-1:0] match_q;
  logic          arm_q, mask_q, stat_q;

  wire ctrl_wr   = cmp_wr && cmp_addr == OFS_CTRL;
  wire disarm_wr = ctrl_wr && !cmp_wdata[0];
  wire reached   = count_q >= match_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       count_q <= '0;
    else if (tick_en) count_q <= count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      match_q <= '0;
    end else if (cmp_wr) begin
      if (cmp_addr == OFS_CMP_LO) match_q[31:0]    <= cmp_wdata;
      if (cmp_addr == OFS_CMP_HI) match_q[CW-1:32] <= cmp_wdata[HW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_q  <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctrl_wr) begin
      arm_q  <= cmp_wdata[0];
      mask_q <= cmp_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                stat_q <= 1'b0;
    else if (disarm_wr)        stat_q <= 1'b0;
    else if (arm_q && reached) stat_q <= 1'b1;
    else if (!arm_q)           stat_q <= 1'b0;

  assign irq = stat_q & ~mask_q;

  always_comb begin
    cnt_rdata = '0;
    if (cnt_rd) begin
      if (cnt_addr == OFS_CNT_LO)      cnt_rdata = count_q[31:0];
      else if (cnt_addr == OFS_CNT_HI) cnt_rdata = {{PW{1'b0}}, count_q[CW-1:32]};
    end
  end

  always_comb begin
    cmp_rdata = '0;
    if (cmp_rd) begin
      if (cmp_addr == OFS_CMP_LO)      cmp_rdata = match_q[31:0];
      else if (cmp_addr == OFS_CMP_HI) cmp_rdata = {{PW{1'b0}}, match_q[CW-1:32]};
      else if (cmp_addr == OFS_CTRL)   cmp_rdata = {29'd0, stat_q, mask_q, arm_q};
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count_q));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && &count_q) |=> count_q == '0);
  assert_cmp_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_rd && cmp_addr == OFS_CMP_HI) |-> cmp_rdata[31:HW] == '0);
  assert_set_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(arm_q));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !disarm_wr) |=> stat_q);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> !stat_q);
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);
endmodule

// File: tb/sysctr_cmp_test.sv
`timescale 1ns/1ps
module sysctr_cmp_test;
  logic clk = 0, rst_n = 0, tick_en = 0;
  logic cnt_rd = 0, cmp_rd = 0, cmp_wr = 0;
  logic [7:0] cnt_addr = 0, cmp_addr = 0;
  logic [31:0] cmp_wdata = 0;
  wire [31:0] cnt_rdata, cmp_rdata;
  wire irq;
  int total = 0, bad = 0;
  bit done = 0;

  sysctr_cmp uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_rd(cnt_rd), .cnt_addr(cnt_addr), .cnt_rdata(cnt_rdata),
    .cmp_rd(cmp_rd), .cmp_wr(cmp_wr), .cmp_addr(cmp_addr),
    .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference
  logic [55:0] m_cnt, m_cmp;
  bit m_arm, m_mask, m_stat;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt <= 0; m_cmp <= 0; m_arm <= 0; m_mask <= 0; m_stat <= 0;
    end else begin
      if (tick_en) m_cnt <= m_cnt + 56'd1;
      if (cmp_wr && cmp_addr == 8'h20) m_cmp[31:0] <= cmp_wdata;
      if (cmp_wr && cmp_addr == 8'h24) m_cmp[55:32] <= cmp_wdata[23:0];
      if (cmp_wr && cmp_addr == 8'h2C) begin m_arm <= cmp_wdata[0]; m_mask <= cmp_wdata[1]; end
      if (cmp_wr && cmp_addr == 8'h2C && !cmp_wdata[0]) m_stat <= 0;
      else if (!m_arm) m_stat <= 0;
      else if (m_cnt >= m_cmp) m_stat <= 1;
    end

  function automatic logic [31:0] exp_cnt();
    if (!cnt_rd) return 0;
    if (cnt_addr == 8'h08) return m_cnt[31:0];
    if (cnt_addr == 8'h0C) return {8'd0, m_cnt[55:32]};
    return 0;
  endfunction
  function automatic logic [31:0] exp_cmp();
    if (!cmp_rd) return 0;
    if (cmp_addr == 8'h20) return m_cmp[31:0];
    if (cmp_addr == 8'h24) return {8'd0, m_cmp[55:32]};
    if (cmp_addr == 8'h2C) return {29'd0, m_stat, m_mask, m_arm};
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 irq", {31'd0, irq}, {31'd0, m_stat & ~m_mask});
    chk((cnt_addr == 8'h08 || cnt_addr == 8'h0C) ? "R1 R2 counter" : "R9 counter window",
        cnt_rdata, exp_cnt());
    chk(cmp_addr == 8'h2C ? "R4 R5 R6 control" :
        (cmp_addr == 8'h20 || cmp_addr == 8'h24) ? "R3 compare" : "R9 compare window",
        cmp_rdata, exp_cmp());
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 cmp_wr = 1; cmp_addr = a; cmp_wdata = d;
    @(posedge clk); #1 cmp_wr = 0; cmp_addr = 8'h2C;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    // R8: reset values seen while still in reset
    cnt_rd = 1; cmp_rd = 1;
    foreach (uut.count_q[i]) ;
    cnt_addr = 8'h08; cmp_addr = 8'h20; #1;
    chk("R8 cnt lo", cnt_rdata, 0); chk("R8 cmp lo", cmp_rdata, 0);
    cnt_addr = 8'h0C; cmp_addr = 8'h24; #1;
    chk("R8 cnt hi", cnt_rdata, 0); chk("R8 cmp hi", cmp_rdata, 0);
    cmp_addr = 8'h2C; #1;
    chk("R8 ctrl", cmp_rdata, 0); chk("R8 irq", {31'd0, irq}, 0);
    @(negedge clk); rst_n = 1;
    // R1: irregular tick pattern, counter window alternating offsets
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1 tick_en = (i % 3) != 1; cnt_addr = (i % 2) ? 8'h0C : 8'h08;
    end
    tick_en = 1; cnt_addr = 8'h08;
    // R5: future compare, fires once reached
    wr(8'h24, 32'h0);
    wr(8'h20, m_cnt[31:0] + 32'd15);
    wr(8'h2C, 32'h1);
    idle(25);
    // R6: rewrite control keeping arm, bit2 written 0 and 1: no clear
    wr(8'h2C, 32'h1);
    wr(8'h2C, 32'h5);
    // R7: masked then unmasked
    wr(8'h2C, 32'h3);
    idle(3);
    wr(8'h2C, 32'h1);
    // R6: disarm clears
    wr(8'h2C, 32'h0);
    idle(3);
    // R5: compare in the past fires right after arming
    wr(8'h20, 32'd5);
    wr(8'h2C, 32'h1);
    idle(3);
    wr(8'h2C, 32'h2);
    // R3: upper word bits 31:24 dropped; far compare never fires
    cmp_addr = 8'h24;
    wr(8'h24, 32'hFFFF_FFFF);
    cmp_addr = 8'h24; idle(2);
    wr(8'h2C, 32'h1);
    idle(20);
    // R9: unmapped offsets and read strobes low
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1 cmp_addr = 8'(i * 4); cnt_addr = 8'(i * 4);
    end
    @(posedge clk); #1 cnt_rd = 0; cmp_rd = 0; cnt_addr = 8'h08; cmp_addr = 8'h2C;
    idle(3);
    // R1: stall ticks, counter must hold
    cnt_rd = 1; tick_en = 0; idle(5);
    tick_en = 1; idle(2);
    @(negedge clk); done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule